// File: doc/BRIEF.md
# Single-Adder Arithmetic and Logic Unit

This block is a W-bit two's-complement arithmetic and logic unit in which every operation, the bitwise ones included, is produced by one shared ripple-carry adder. A front-end operand shaper looks at a 3-bit operation code. From it, the shaper forms the adder's two inputs and its carry-in so that the adder's output is the answer that was asked for. No separate logic unit is muxed in after the adder.

The adder output, its carry-out and a signed overflow flag are captured in registers. A new operation can be presented on every clock cycle, and its result appears on the outputs one cycle later. An asynchronous active-low reset clears all three outputs.

Top module: `addalu_top`

## Requirements
- R1: Opcode 3'b000 (add) gives sum = (A + B) mod 2^W, and carry-out is bit W of the unsigned sum A + B.
- R2: Opcode 3'b001 (subtract) gives sum = (A - B) mod 2^W, formed as A + ~B + 1. Carry-out is 1 exactly when A >= B as unsigned numbers (no borrow).
- R3: Opcode 3'b010 (increment) gives sum = (A + 1) mod 2^W. Carry-out is 1 only when A is all ones.
- R4: Opcode 3'b011 (pass) gives sum = A, with carry-out 0.
- R5: Opcode 3'b100 gives sum = A AND B, with carry-out 0.
- R6: Opcode 3'b101 gives sum = A OR B, with carry-out 0.
- R7: Opcode 3'b110 gives sum = A XOR B, with carry-out 0.
- R8: Opcode 3'b111 gives sum = NOT A (bitwise inverse), with carry-out 0.
- R9: For opcodes 3'b000 to 3'b011, the overflow flag is 1 exactly when the signed result falls outside [-2^(W-1), 2^(W-1)-1]. This is the case when the adder's two operands share a sign and the result's sign differs. For W=8: 0x7F+0x01, 0x80-0x01 and increment of 0x7F all flag overflow.
- R10: For the bitwise opcodes 3'b100 to 3'b111, the overflow flag and the carry-out are both 0, whatever the operands.
- R11: Outputs show the operation whose inputs were present at the previous rising clock edge, and back-to-back operations are each reported in turn. While the reset input is low, sum, carry-out and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| op_i | input | 3 | Operation code |
| sum_o | output | W | Registered result |
| carry_o | output | 1 | Registered adder carry-out |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The bench goes after the sign boundaries: the largest positive number plus one, the most negative number minus one, and incrementing the largest positive value. A unit that took overflow from the carry-out alone, or from the wrong carry pair, would flag or miss these cases. Subtraction of equal operands and of a larger operand from a smaller one checks the no-borrow carry convention, which an adder fed a missing carry-in or an uninverted B would get wrong. The bitwise opcodes are driven with operands that would overflow if added, so a shaper that leaks B into the adder, or a flag path that is not masked, shows up as a wrong result or a stray flag. Back-to-back opcode changes and a reset in mid-stream expose an output register that is off by one cycle or is not cleared.

// File: rtl/addalu_pkg.sv
package addalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_PASS = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_NOTA = 3'b111
  } alu_op_e;

  // Bitwise group occupies the upper half of the code space.
  function automatic logic op_is_bitwise(input logic [2:0] op);
    return op[2];
  endfunction

  // One full-adder bit: sum.
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // One full-adder bit: carry (majority).
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // Signed overflow from the two carries around the sign bit.
  function automatic logic sign_carry_ovf(input logic c_into, input logic c_out);
    return c_into ^ c_out;
  endfunction

endpackage

// File: rtl/addalu_shaper.sv
module addalu_shaper
  import addalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] add_a_o,
  output logic [W-1:0] add_b_o,
  output logic         add_cin_o
);

  localparam logic [W-1:0] ZERO = '0;

  always_comb begin
    add_a_o   = a_i;
    add_b_o   = ZERO;
    add_cin_o = 1'b0;
    unique case (alu_op_e'(op_i))
      OP_ADD: begin
        add_b_o = b_i;
      end
      OP_SUB: begin
        add_b_o   = ~b_i;
        add_cin_o = 1'b1;
      end
      OP_INC: begin
        add_cin_o = 1'b1;
      end
      OP_PASS: begin
        add_a_o = a_i;
      end
      OP_AND:  add_a_o = a_i & b_i;
      OP_OR:   add_a_o = a_i | b_i;
      OP_XOR:  add_a_o = a_i ^ b_i;
      OP_NOTA: add_a_o = ~a_i;
      default: add_a_o = a_i;
    endcase
  end

endmodule

// File: rtl/addalu_fa_cell.sv
module addalu_fa_cell
  import addalu_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  assign s_o = fa_sum(x_i, y_i, c_i);
  assign c_o = fa_carry(x_i, y_i, c_i);

endmodule

// File: rtl/addalu_ripple.sv
module addalu_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W:0]   carry_o
);

  assign carry_o[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    addalu_fa_cell u_fa (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (carry_o[k]),
      .s_o (sum_o[k]),
      .c_o (carry_o[k+1])
    );
  end

endmodule

// File: rtl/addalu_flags.sv
module addalu_flags
  import addalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W:0] carry_i,
  input  logic [2:0] op_i,
  output logic       cout_o,
  output logic       ovf_o
);

  localparam int MSB = W - 1;

  logic raw_ovf;
  assign raw_ovf = sign_carry_ovf(carry_i[MSB], carry_i[W]);
  assign cout_o  = carry_i[W];
  assign ovf_o   = raw_ovf & ~op_is_bitwise(op_i);

endmodule

// File: rtl/addalu_top.sv
module addalu_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic [W-1:0] ext_a_w;
  logic [W-1:0] ext_b_w;
  logic         ext_cin_w;
  logic [W-1:0] add_sum_w;
  logic [W:0]   add_carry_w;
  logic         cout_w;
  logic         ovf_w;

  addalu_shaper #(.W(W)) u_shaper (
    .a_i       (a_i),
    .b_i       (b_i),
    .op_i      (op_i),
    .add_a_o   (ext_a_w),
    .add_b_o   (ext_b_w),
    .add_cin_o (ext_cin_w)
  );

  addalu_ripple #(.W(W)) u_adder (
    .x_i     (ext_a_w),
    .y_i     (ext_b_w),
    .cin_i   (ext_cin_w),
    .sum_o   (add_sum_w),
    .carry_o (add_carry_w)
  );

  addalu_flags #(.W(W)) u_flags (
    .carry_i (add_carry_w),
    .op_i    (op_i),
    .cout_o  (cout_w),
    .ovf_o   (ovf_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      sum_o   <= add_sum_w;
      carry_o <= cout_w;
      ovf_o   <= ovf_w;
    end
  end

endmodule

// File: rtl/addalu_chk.sv
module addalu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] sum_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic [W-1:0] ext_a,
  input logic [W-1:0] ext_b,
  input logic [W-1:0] add_sum
);

  localparam int MSB = W - 1;

  a_r1_add: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b000 |=> {carry_o, sum_o} == $past({1'b0, a_i} + {1'b0, b_i}));

  a_r2_sub: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b001 |=> (sum_o == $past(a_i - b_i)) && (carry_o == $past(a_i >= b_i)));

  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b010 |=> sum_o == $past(a_i + 1'b1));

  a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b011 |=> (sum_o == $past(a_i)) && !carry_o && !ovf_o);

  a_r5_and: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b100 |=> sum_o == $past(a_i & b_i));

  a_r6_or: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b101 |=> sum_o == $past(a_i | b_i));

  a_r7_xor: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b110 |=> sum_o == $past(a_i ^ b_i));

  a_r8_nota: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b111 |=> sum_o == $past(~a_i));

  // R9: operand-sign rule on the adder's actual inputs
  a_r9_ovf_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    !op_i[2] |=> ovf_o == $past((ext_a[MSB] == ext_b[MSB]) && (add_sum[MSB] != ext_a[MSB])));

  a_r10_bitwise_flags: assert property (@(posedge clk) disable iff (!rst_n)
    op_i[2] |=> !ovf_o && !carry_o);

endmodule

bind addalu_top addalu_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o),
  .ext_a   (ext_a_w),
  .ext_b   (ext_b_w),
  .add_sum (add_sum_w)
);

// File: tb/addalu_top_tb.sv
`timescale 1ns/1ps
module addalu_top_tb;

  localparam int W    = 8;
  localparam int MAXS = (1 << (W-1)) - 1;
  localparam int MINS = -(1 << (W-1));
  localparam int FULL = (1 << W);

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   op;
    logic [W-1:0] sum;
    logic         cy;
    logic         ov;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [2:0]   op_i = '0;
  logic [W-1:0] sum_o;
  logic         carry_o;
  logic         ovf_o;

  int n_vec = 0;
  int n_bad = 0;
  item_t sb_q[$];

  always #4 clk = ~clk;

  addalu_top #(.W(W)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_i),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
  );

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Reference model from the requirements, integer arithmetic only
  function automatic item_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [2:0] op);
    item_t r;
    int ua = int'(a);
    int ub = int'(b);
    int sa = int'($signed(a));
    int sb = int'($signed(b));
    int full = 0;
    int sres = 0;
    r.a = a; r.b = b; r.op = op;
    r.cy = 1'b0; r.ov = 1'b0;
    case (op)
      3'd0: begin full = ua + ub; sres = sa + sb; r.cy = (full >= FULL); end
      3'd1: begin full = ua - ub + FULL; sres = sa - sb; r.cy = (ua >= ub); end
      3'd2: begin full = ua + 1; sres = sa + 1; r.cy = (ua == FULL - 1); end
      3'd3: begin full = ua; sres = sa; end
      3'd4: full = int'(a & b);
      3'd5: full = int'(a | b);
      3'd6: full = int'(a ^ b);
      default: full = int'(~a);
    endcase
    r.sum = full[W-1:0];
    if (op < 3'd4) r.ov = (sres > MAXS) || (sres < MINS);
    return r;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] op);
    @(negedge clk);
    a_i = a; b_i = b; op_i = op;
    sb_q.push_back(model(a, b, op));
  endtask

  // Monitor: each pushed item is registered at the next rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && sb_q.size() > 0) begin
      item_t e;
      e = sb_q.pop_front();
      n_vec++;
      if (sum_o !== e.sum) begin
        n_bad++;
        $display("FAIL %s/R11 op=%0d a=%h b=%h sum actual=%h expected=%h",
                 op_tag(e.op), e.op, e.a, e.b, sum_o, e.sum);
      end
      if (carry_o !== e.cy) begin
        n_bad++;
        $display("FAIL %s carry op=%0d a=%h b=%h actual=%b expected=%b",
                 (e.op[2] ? "R10" : op_tag(e.op)), e.op, e.a, e.b, carry_o, e.cy);
      end
      if (ovf_o !== e.ov) begin
        n_bad++;
        $display("FAIL %s overflow op=%0d a=%h b=%h actual=%b expected=%b",
                 (e.op[2] ? "R10" : "R9"), e.op, e.a, e.b, ovf_o, e.ov);
      end
    end
  end

  task automatic check_reset_zero(input string where);
    n_vec++;
    if (sum_o !== '0 || carry_o !== 1'b0 || ovf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset (%s) actual=%h/%b/%b expected=00/0/0",
               where, sum_o, carry_o, ovf_o);
    end
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check_reset_zero("power-up");   // R11
    rst_n = 1'b1;

    // R1 / R9: add, sign boundaries
    drive(8'h7F, 8'h01, 3'd0);
    drive(8'h80, 8'hFF, 3'd0);
    drive(8'hFF, 8'h01, 3'd0);
    drive(8'h12, 8'h34, 3'd0);
    // R2 / R9: subtract, borrow and overflow corners
    drive(8'h80, 8'h01, 3'd1);
    drive(8'h55, 8'h55, 3'd1);
    drive(8'h03, 8'h07, 3'd1);
    drive(8'h7F, 8'hFF, 3'd1);
    // R3 / R9: increment
    drive(8'h7F, 8'h00, 3'd2);
    drive(8'hFF, 8'hAA, 3'd2);
    // R4: pass with B ignored
    drive(8'hC3, 8'hFF, 3'd3);
    // R5..R8 / R10: bitwise ops on operands that would overflow if added
    drive(8'h7F, 8'h7F, 3'd4);
    drive(8'h80, 8'h80, 3'd5);
    drive(8'hF0, 8'hFF, 3'd6);
    drive(8'h00, 8'hFF, 3'd7);
    drive(8'hFF, 8'hFF, 3'd4);

    // R11: back-to-back opcode changes
    for (int k = 0; k < 8; k++) drive(8'h7F, 8'h81, 3'(k));

    // Random mix over all opcodes
    for (int k = 0; k < 400; k++)
      drive(W'($urandom), W'($urandom), 3'($urandom));

    drive(8'hA5, 8'h5A, 3'd6);
    drain();
    // R11: reset mid-stream clears outputs at once
    rst_n = 1'b0;
    #1;
    check_reset_zero("mid-run");
    @(negedge clk);
    check_reset_zero("held");
    rst_n = 1'b1;
    drive(8'h01, 8'h02, 3'd0);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule